// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a 48-line digital input port and raises an interrupt when a line changes level. It sits behind an 8-byte register window with a byte-wide data path and single-cycle read and write strobes. Software reads the input levels as six byte registers. Through one shared interrupt register it arms 8-line groups for change detection and learns which groups changed.

Each input first passes through a two-flop synchronizer. A group whose enable bit is set latches a flag when any of its eight lines rises or falls. The interrupt output is a level that stays high while any flag is latched. A read of the interrupt register returns the group flags and an active-low request bit, and that read clears the flags. A change that lands in the same cycle as the clearing read is kept for the next read.

Read data is combinational from the address and read strobe. A clearing read takes effect at the clock edge that ends the strobe cycle.

Top module: `cos_input_port`

## Requirements
- R1: After reset every group enable is clear, no flag is latched, `irq` is low and a read of offset 7 returns 0x40.
- R2: Reads of offsets 0, 1 and 2 return input bits [7:0], [15:8] and [23:16]. Reads of offsets 4, 5 and 6 return bits [31:24], [39:32] and [47:40]. A level driven before a rising edge appears on reads after the second rising edge.
- R3: A read of offset 3 returns 0x00.
- R4: A write to offset 7 loads bits 0 to 5 as the enable mask, where bit n arms group n (inputs 8n to 8n+7). Bits 6 and 7 of the write are ignored, and writing 0 disables every group.
- R5: On an armed group, a rising or falling edge on any of its lines latches flag bit n, and `irq` goes high after the third rising edge following the input change.
- R6: A change on a group whose enable bit is clear latches no flag and leaves `irq` low.
- R7: A read of offset 7 returns the group flags in bits 0 to 5, bit 6 equal to 0 while a flag is latched and 1 otherwise, and bit 7 equal to 0.
- R8: A read of offset 7 clears all flags, and `irq` is low after that cycle's clock edge.
- R9: A change detected in the same cycle as a clearing read is latched, so `irq` stays high and the next read reports that group.
- R10: Writing an enable mask with bit n clear discards a pending flag of group n.
- R11: Writes to offsets 0 to 6 have no effect, and reads of offsets 0 to 6 do not clear flags.
- R12: While any flag is latched and offset 7 is neither read nor written, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 48 | Asynchronous digital inputs |
| bus_addr | input | 3 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt request, high while a flag is latched |

## Verification
The bench builds the block with its default parameters: six groups of eight lines and a two-stage synchronizer. These values make both banks, the unused offset and every status bit reachable through the fixed 8-byte window. The two-stage latency puts the change-detect cycle exactly two negative edges after an input change. Because of that, the bench can place a clearing read in the detect cycle and exercise the read/change collision on demand.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int unsigned BANK_GROUPS  = 3;
    localparam logic [2:0]  OFF_IRQ      = 3'd7;
    localparam logic [1:0]  IDX_RESERVED = 2'd3;
    localparam int unsigned REQ_BIT      = 6;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int unsigned WIDTH  = 48,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_in;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.pipe[STAGES-1];
endmodule

// File: rtl/cos_group.sv
module cos_group #(
    parameter int unsigned GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] lines,
    input  logic          arm_nxt,
    input  logic          clr,
    output logic          chg,
    output logic          flag
);
    typedef struct packed {
        logic [GW-1:0] prev;
        logic          flag;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        chg       = |(lines ^ st_q.prev);
        st_d.prev = lines;
        st_d.flag = arm_nxt & ((st_q.flag & ~clr) | chg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R5: an edge seen on an armed group is latched
    a_r5_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_nxt && chg) |=> flag);
endmodule

// File: rtl/cos_regs.sv
module cos_regs
    import cos_pkg::*;
#(
    parameter int unsigned GW = 8,
    parameter int unsigned NG = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic            wr,
    input  logic [2:0]      addr,
    input  logic [GW-1:0]   wdata,
    input  logic [NG*GW-1:0] levels,
    input  logic [NG-1:0]   flags,
    output logic [GW-1:0]   rdata,
    output logic [NG-1:0]   arm_nxt,
    output logic            status_clr
);
    typedef struct packed {
        logic [NG-1:0] arm;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit_irq;
    int unsigned gidx;

    always_comb begin
        st_d    = st_q;
        hit_irq = (addr == OFF_IRQ);
        if (wr && hit_irq) st_d.arm = wdata[NG-1:0];
        arm_nxt    = st_d.arm;
        status_clr = rd && hit_irq;

        gidx  = (addr[2] ? BANK_GROUPS : 0) + int'(addr[1:0]);
        rdata = '0;
        if (hit_irq) begin
            rdata[NG-1:0]  = flags;
            rdata[REQ_BIT] = ~|flags;
        end else if (addr[1:0] != IDX_RESERVED && gidx < NG) begin
            rdata = levels[gidx*GW +: GW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the unused offset reads as zero
    a_r3_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 3'd3) |-> (rdata == '0));
    // R7: top status bit is always zero
    a_r7_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_irq) |-> (rdata[GW-1] == 1'b0));
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
    import cos_pkg::*;
#(
    parameter int unsigned GROUP_W     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [6*GROUP_W-1:0] din,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [GROUP_W-1:0]   bus_wdata,
    output logic [GROUP_W-1:0]   bus_rdata,
    output logic                 irq
);
    localparam int unsigned NG   = 2 * BANK_GROUPS;
    localparam int unsigned N_IN = NG * GROUP_W;

    logic [N_IN-1:0] levels;
    logic [NG-1:0]   flag_vec;
    logic [NG-1:0]   chg_vec;
    logic [NG-1:0]   arm_nxt;
    logic            status_clr;

    cos_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (din),
        .sync_out (levels)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        cos_group #(.GW(GROUP_W)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines   (levels[g*GROUP_W +: GROUP_W]),
            .arm_nxt (arm_nxt[g]),
            .clr     (status_clr),
            .chg     (chg_vec[g]),
            .flag    (flag_vec[g])
        );
    end

    cos_regs #(.GW(GROUP_W), .NG(NG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .levels     (levels),
        .flags      (flag_vec),
        .rdata      (bus_rdata),
        .arm_nxt    (arm_nxt),
        .status_clr (status_clr)
    );

    assign irq = |flag_vec;

    // R8: a clearing read with no new change drops the request
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && chg_vec == '0) |=> !irq);
    // R12: request holds while the interrupt register is untouched
    a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !((bus_rd || bus_wr) && bus_addr == OFF_IRQ)) |=> irq);
    // R4 / R6: an all-zero enable write leaves nothing pending
    a_r6_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_IRQ && bus_wdata[NG-1:0] == '0) |=> !irq);
    // R7: request bit is the inverse of the interrupt level
    a_r7_req_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_IRQ) |-> (bus_rdata[REQ_BIT] == !irq));
endmodule

// File: tb/test_cos_input_port.sv
module test_cos_input_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] din = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    cos_input_port i_cos_input_port (
        .clk(clk), .rst_n(rst_n), .din(din), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input logic e, input string req);
        chk(irq === e, req, {7'd0, irq}, {7'd0, e});
    endtask

    // driver: push expected read data, then strobe
    task automatic do_read(input logic [2:0] a, input logic [7:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare while a read strobe is active
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "queue", bus_rdata, 8'h00);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(bus_rdata === e, t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk_irq(1'b0, "R1");
        do_read(3'd7, 8'h40, "R1");

        // R2 / R3: input bytes and latency, enables all clear
        din = 48'h665544_332211;
        wait_n(1);
        do_read(3'd0, 8'h00, "R2");
        do_read(3'd0, 8'h11, "R2");
        do_read(3'd1, 8'h22, "R2");
        do_read(3'd2, 8'h33, "R2");
        do_read(3'd3, 8'h00, "R3");
        do_read(3'd4, 8'h44, "R2");
        do_read(3'd5, 8'h55, "R2");
        do_read(3'd6, 8'h66, "R2");
        do_read(3'd7, 8'h40, "R6");
        chk_irq(1'b0, "R6");

        // R4: only group 0 armed, upper write bits ignored
        do_write(3'd7, 8'hC1);
        din ^= 48'h1 << 8;
        wait_n(4);
        chk_irq(1'b0, "R6");
        do_read(3'd7, 8'h40, "R4");

        // R5: rising edge on group 0, timing of irq
        din ^= 48'h1 << 3;
        wait_n(2);
        chk_irq(1'b0, "R5");
        wait_n(1);
        chk_irq(1'b1, "R5");
        wait_n(5);
        chk_irq(1'b1, "R12");
        do_read(3'd7, 8'h01, "R7");
        chk_irq(1'b0, "R8");
        do_read(3'd7, 8'h40, "R8");

        // R5: falling edge
        din ^= 48'h1 << 3;
        wait_n(4);
        do_read(3'd7, 8'h01, "R5");

        // R5: all groups armed, bank B mapping
        do_write(3'd7, 8'h3F);
        din ^= 48'h1 << 47;
        wait_n(4);
        do_read(3'd6, 8'hE6, "R2");
        do_read(3'd7, 8'h20, "R5");
        din ^= 48'h1 << 24;
        wait_n(4);
        do_read(3'd7, 8'h08, "R5");

        // R9: change in the same cycle as the clearing read
        din ^= 48'h1;
        wait_n(4);
        chk_irq(1'b1, "R9");
        din ^= 48'h1 << 9;
        wait_n(2);
        do_read(3'd7, 8'h01, "R9");
        chk_irq(1'b1, "R9");
        do_read(3'd7, 8'h02, "R9");
        chk_irq(1'b0, "R9");

        // R10: disarming a group drops its pending flag
        din ^= 48'h1 << 16;
        wait_n(4);
        chk_irq(1'b1, "R10");
        do_write(3'd7, 8'h3B);
        chk_irq(1'b0, "R10");
        do_read(3'd7, 8'h40, "R10");

        // R11: other offsets neither clear nor reconfigure
        din ^= 48'h1 << 40;
        wait_n(4);
        do_read(3'd0, din[7:0], "R11");
        do_write(3'd3, 8'h00);
        do_write(3'd0, 8'h00);
        chk_irq(1'b1, "R11");
        do_read(3'd7, 8'h20, "R11");

        // R4: writing zero disables every group
        do_write(3'd7, 8'h00);
        din ^= 48'hFFFF_FFFF_FFFF;
        wait_n(4);
        chk_irq(1'b0, "R4");
        do_read(3'd7, 8'h40, "R4");

        wait_n(2);
        chk(exp_q.size() == 0, "queue", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule